// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits in front of a small NOR-style flash array. It decodes bus writes into commands and runs the program and erase operations from internal cycle counters. It also keeps an 8-bit status register that software polls. Writes are taken on the rising edge of a write-enable strobe. Reads return either array data or the status register, depending on the last command accepted.

Programming takes two writes: a setup code, then a write that carries address and data. Erasing takes a setup code and then a confirm code; the confirm write carries the block address. A running erase can be suspended. While it is suspended, a word in another block can be programmed and any block can be read. An erase resume sent during that program is held until the program ends. Two input pins, one reporting the programming supply level and one asking for protection of the boot block, lead to rejected operations with their own status flags.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the whole array reads 0xFFFF, reads return array data, and the status register reads 0x80.
- R2: Code 0xFF selects array reads, where `rdata` combinationally shows the word at `addr`. Code 0x70 selects status reads, where `rdata[7:0]` is the status register and `rdata[15:8]` is zero. Status bit 7 is ready, bit 6 erase-suspended, bit 5 erase/sequence error, bit 4 program error, bit 3 supply error and bit 1 lock error; bits 2 and 0 are zero.
- R3: Setup code 0x40 or 0x10 followed by an address/data write programs one word. Address and data are taken at the rising edge of `wr_en`. Status bit 7 stays 0 for PROG_CYC cycles from the data write. The stored word becomes old AND new.
- R4: After a program, erase, suspend or resume command is accepted, reads return status without a 0x70 write. This lasts until 0xFF is written.
- R5: When the program ends, status bit 4 is set if any bit of the new data is 1 where the old word held 0.
- R6: With `vpp_ok` low, a program sets bits 3 and 4 and an erase sets bits 3 and 5. With `protect` high, a program to block 0 sets bits 1 and 4 and an erase of block 0 sets bits 1 and 5. In all four cases the array is left unchanged.
- R7: Code 0x20 followed by 0xD0 erases the block addressed by the second write. The block's top BLK_W address bits select it. Every word of the block becomes 0xFFFF after ERASE_CYC running cycles, and bit 7 reads 0 until then.
- R8: Code 0xB0 during an erase stops the erase count. SUSP_LAT cycles later, bits 7 and 6 both read 1.
- R9: While suspended, 0xFF, 0x70, a program to another block, and 0xD0 are accepted. A program to another block shows bit 7 = 0 and bit 6 = 1 while it runs. A program to the suspended block is rejected with bit 4 and changes nothing. Other codes, 0x50 included, are ignored.
- R10: 0xD0 while suspended clears bits 6 and 7 and continues the erase for its remaining cycles. If a program is running, this waits until the program completes.
- R11: In idle, any code other than 0xFF, 0x70, 0x50, 0x40, 0x10 or 0x20 sets bits 4 and 5. A second erase write that is not 0xD0 does the same.
- R12: Bits 1, 3, 4 and 5 stay set through other commands until 0x50 is written in idle.
- R13: While a program runs, every write except 0x70 (and 0xD0 during a suspend) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; one bus write per rising edge |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 16 | Write data; command code in bits 7:0 |
| vpp_ok | input | 1 | Programming supply is in range |
| protect | input | 1 | Boot block 0 is locked |
| rdata | output | 16 | Array word or status register |

## Verification
Each write is seen at the clock edge where `wr_en` is first high. A program loaded at write edge E finishes at edge E+PROG_CYC. An erase started at edge E finishes at E+ERASE_CYC, plus any cycles spent suspended. A suspend takes effect SUSP_LAT edges after the 0xB0 edge. The bench counts every edge from the write it issues. It samples status one edge before each due point, where the block must still be busy, and again at the due point, where it must have changed. The nested suspend case follows the deferred resume to the exact edge where the program ends and the erase count restarts.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int WORD_W = 16;

  localparam logic [7:0] CMD_READ_ARR = 8'hFF;
  localparam logic [7:0] CMD_READ_SR  = 8'h70;
  localparam logic [7:0] CMD_CLR_SR   = 8'h50;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;

  typedef enum logic [1:0] {PEND_NONE, PEND_PROG, PEND_ERASE} pend_e;

  // Programming can only pull bits low.
  function automatic logic [WORD_W-1:0] prog_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w);
    return old_w & new_w;
  endfunction

  // Verify fault: a requested 1 sits over a stored 0.
  function automatic logic prog_fault(input logic [WORD_W-1:0] old_w,
                                      input logic [WORD_W-1:0] new_w);
    return |(new_w & ~old_w);
  endfunction
endpackage

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (load_i)                 cnt <= CNT_W'(LEN);
    else if (run_i && cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
  assign done_o = run_i && (cnt == CNT_W'(1));

  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> (busy_o == $past(busy_o))); // R8
endmodule

// File: rtl/fl_array.sv
module fl_array
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              ers_i,
  input  logic [BLK_W-1:0]  ers_blk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic [WORD_W-1:0] chk_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NBLK  = 1 << BLK_W;
  localparam int SHIFT = ADDR_W - BLK_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [NBLK-1:0]   blk_hit;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    assign blk_hit[g] = ers_i && (ers_blk_i == BLK_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (ers_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (blk_hit[i >> SHIFT]) mem[i] <= '1;
    end else if (wr_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o  = mem[rd_addr_i];
  assign chk_data_o = mem[chk_addr_i];

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> ((wr_data_i & ~mem[wr_addr_i]) == '0)); // R3
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 2,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 20,
  parameter int SUSP_LAT  = 3,
  parameter int LOCK_BLK  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              vpp_ok,
  input  logic              protect,
  output logic [WORD_W-1:0] rdata
);
  logic        we_q, wr_evt;
  logic [7:0]  cmd;
  logic [BLK_W-1:0] blk;
  pend_e       pend_q, nxt_pend;
  logic        sr_mode_q, nxt_mode;
  logic        e_lock_q, e_vpp_q, e_prog_q, e_ers_q;
  logic [ADDR_W-1:0] prog_addr_q;
  logic [WORD_W-1:0] prog_data_q;
  logic [BLK_W-1:0]  erase_blk_q;
  logic        erase_susp_q, resume_pend_q;

  logic prog_busy, prog_done, ers_busy, ers_done, ers_run, susp_req, sus_done;
  logic prog_start, ers_start, sus_start, resume_cmd, clr_cmd, seq_err;
  logic set_lock, set_vpp, set_prog, set_ers;
  logic lock_hit, susp_hit, is_prog_code, ready, verify_bad;
  logic [WORD_W-1:0] rd_word, old_word;
  logic [7:0] sr;

  assign wr_evt       = wr_en && !we_q;
  assign cmd          = wdata[7:0];
  assign blk          = addr[ADDR_W-1 -: BLK_W];
  assign lock_hit     = protect && (blk == BLK_W'(LOCK_BLK));
  assign susp_hit     = ers_busy && (blk == erase_blk_q);
  assign is_prog_code = (cmd == CMD_PROG) || (cmd == CMD_PROG_ALT);
  assign ers_run      = ers_busy && !erase_susp_q && !susp_req;
  assign ready        = !(prog_busy || (ers_busy && !erase_susp_q));
  assign verify_bad   = prog_done && prog_fault(old_word, prog_data_q);

  fl_timer #(.LEN(PROG_CYC)) u_prog_tmr (
    .clk, .rst_n, .load_i(prog_start), .run_i(1'b1),
    .busy_o(prog_busy), .done_o(prog_done));

  fl_timer #(.LEN(ERASE_CYC)) u_ers_tmr (
    .clk, .rst_n, .load_i(ers_start), .run_i(ers_run),
    .busy_o(ers_busy), .done_o(ers_done));

  fl_timer #(.LEN(SUSP_LAT)) u_sus_tmr (
    .clk, .rst_n, .load_i(sus_start), .run_i(1'b1),
    .busy_o(susp_req), .done_o(sus_done));

  fl_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
    .clk, .rst_n,
    .wr_i(prog_done), .wr_addr_i(prog_addr_q),
    .wr_data_i(prog_merge(old_word, prog_data_q)),
    .ers_i(ers_done), .ers_blk_i(erase_blk_q),
    .rd_addr_i(addr), .rd_data_o(rd_word),
    .chk_addr_i(prog_addr_q), .chk_data_o(old_word));

  // Command decode
  always_comb begin
    nxt_pend = pend_q;   nxt_mode = sr_mode_q;
    prog_start = 1'b0;   ers_start = 1'b0;  sus_start = 1'b0;
    resume_cmd = 1'b0;   clr_cmd = 1'b0;    seq_err = 1'b0;
    set_lock = 1'b0;     set_vpp = 1'b0;    set_prog = 1'b0;  set_ers = 1'b0;
    if (wr_evt) begin
      if (pend_q == PEND_PROG) begin
        nxt_pend = PEND_NONE;  nxt_mode = 1'b1;
        if (!vpp_ok || lock_hit || susp_hit) begin
          set_prog = 1'b1;  set_vpp = !vpp_ok;  set_lock = lock_hit;
        end else begin
          prog_start = 1'b1;
        end
      end else if (pend_q == PEND_ERASE) begin
        nxt_pend = PEND_NONE;  nxt_mode = 1'b1;
        if (cmd != CMD_CONFIRM) begin
          seq_err = 1'b1;
        end else if (!vpp_ok || lock_hit) begin
          set_ers = 1'b1;  set_vpp = !vpp_ok;  set_lock = lock_hit;
        end else begin
          ers_start = 1'b1;
        end
      end else if (prog_busy) begin
        if (cmd == CMD_READ_SR) nxt_mode = 1'b1;
        else if (cmd == CMD_CONFIRM && erase_susp_q) begin
          resume_cmd = 1'b1;  nxt_mode = 1'b1;
        end
      end else if (ers_busy && !erase_susp_q) begin
        if (cmd == CMD_READ_SR) nxt_mode = 1'b1;
        else if (cmd == CMD_SUSPEND && !susp_req) begin
          sus_start = 1'b1;  nxt_mode = 1'b1;
        end
      end else if (ers_busy) begin
        if (cmd == CMD_READ_ARR)      nxt_mode = 1'b0;
        else if (cmd == CMD_READ_SR)  nxt_mode = 1'b1;
        else if (is_prog_code) begin
          nxt_pend = PEND_PROG;  nxt_mode = 1'b1;
        end else if (cmd == CMD_CONFIRM) begin
          resume_cmd = 1'b1;  nxt_mode = 1'b1;
        end
      end else begin
        if (cmd == CMD_READ_ARR)      nxt_mode = 1'b0;
        else if (cmd == CMD_READ_SR)  nxt_mode = 1'b1;
        else if (cmd == CMD_CLR_SR)   clr_cmd = 1'b1;
        else if (is_prog_code) begin
          nxt_pend = PEND_PROG;  nxt_mode = 1'b1;
        end else if (cmd == CMD_ERASE) begin
          nxt_pend = PEND_ERASE;  nxt_mode = 1'b1;
        end else begin
          seq_err = 1'b1;  nxt_mode = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q <= 1'b0;  pend_q <= PEND_NONE;  sr_mode_q <= 1'b0;
      e_lock_q <= 1'b0;  e_vpp_q <= 1'b0;  e_prog_q <= 1'b0;  e_ers_q <= 1'b0;
      prog_addr_q <= '0;  prog_data_q <= '0;  erase_blk_q <= '0;
      erase_susp_q <= 1'b0;  resume_pend_q <= 1'b0;
    end else begin
      we_q      <= wr_en;
      pend_q    <= nxt_pend;
      sr_mode_q <= nxt_mode;
      if (prog_start) begin
        prog_addr_q <= addr;
        prog_data_q <= wdata;
      end
      if (ers_start) erase_blk_q <= blk;
      if (sus_done)                          erase_susp_q <= 1'b1;
      else if (resume_cmd && !prog_busy)     erase_susp_q <= 1'b0;
      else if (prog_done && resume_pend_q)   erase_susp_q <= 1'b0;
      if (resume_cmd && prog_busy) resume_pend_q <= 1'b1;
      else if (prog_done)          resume_pend_q <= 1'b0;
      if (clr_cmd) begin
        e_lock_q <= 1'b0;  e_vpp_q <= 1'b0;  e_prog_q <= 1'b0;  e_ers_q <= 1'b0;
      end else begin
        e_lock_q <= e_lock_q | set_lock;
        e_vpp_q  <= e_vpp_q  | set_vpp;
        e_prog_q <= e_prog_q | set_prog | seq_err | verify_bad;
        e_ers_q  <= e_ers_q  | set_ers  | seq_err;
      end
    end
  end

  assign sr    = {ready, erase_susp_q, e_ers_q, e_prog_q, e_vpp_q, 1'b0, e_lock_q, 1'b0};
  assign rdata = sr_mode_q ? {8'h00, sr} : rd_word;

  AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_busy && ers_run)); // R9
  AST_SUSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_susp_q) |-> $past(susp_req)); // R8
  AST_RESUME_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_susp_q) |-> !prog_busy); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_prog_q) |-> $past(clr_cmd)); // R12
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && wr_evt && pend_q == PEND_NONE) |-> !(prog_start || ers_start || clr_cmd)); // R13
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int ADDR_W = 6, BLK_W = 2, PROG_CYC = 4, ERASE_CYC = 20, SUSP_LAT = 3;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BWORDS = 1 << (ADDR_W - BLK_W);

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, vpp_ok = 1'b1, protect = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [15:0] model [DEPTH];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC),
                   .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)) u_dut (
    .clk, .rst_n, .wr_en, .addr, .wdata, .vpp_ok, .protect, .rdata);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
    step(1);
  endtask

  task automatic sr_is(input string req, input logic [7:0] exp);
    addr = '0; #1;
    check(req, rdata, {8'h00, exp});
  endtask

  task automatic arr_is(input string req, input logic [ADDR_W-1:0] a);
    addr = a; #1;
    check(req, rdata, model[a]);
  endtask

  // program with expected busy window and final status
  task automatic prog(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic [7:0] code);
    logic fail;
    fail = |(d & ~model[a]);
    wr(0, {8'h00, code});
    wr(a, d);
    step(PROG_CYC - 2);
    sr_is("R3 busy", 8'h00);
    step(1);
    sr_is("R5 R4 done", fail ? 8'h90 : 8'h80);
    model[a] = model[a] & d;
    if (fail) wr(0, 16'h0050);
    wr(0, 16'h00FF);
    arr_is("R3 R2 merged word", a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    arr_is("R1 array after reset", 6'd5);
    arr_is("R1 array after reset", 6'd63);
    wr(0, 16'h0070);
    sr_is("R1 R2 status after reset", 8'h80);
    wr(0, 16'h00FF);

    // R3 R5 sweeps over every address, both setup codes
    for (int a = 0; a < DEPTH; a++)
      prog(6'(a), 16'(a * 16'h0B3D) ^ 16'h5A5A, a[0] ? 8'h10 : 8'h40);
    for (int a = 0; a < DEPTH; a++)
      prog(6'(a), 16'(a * 16'h1F07) ^ 16'hC3C3, a[1] ? 8'h40 : 8'h10);

    // R13 writes during a program are ignored
    wr(0, 16'h0040);
    wr(6'd50, 16'h0000);
    wr(0, 16'h00FF);
    sr_is("R13 FF ignored while busy", 8'h00);
    step(1);
    sr_is("R13 done", 8'h80);
    model[50] = 16'h0000;
    wr(0, 16'h00FF);
    arr_is("R13 word", 6'd50);

    // R11 R12 unknown codes and sticky errors
    foreach (model[k]) begin end
    for (int c = 0; c < 5; c++) begin
      logic [7:0] code;
      code = (c == 0) ? 8'h00 : (c == 1) ? 8'h33 : (c == 2) ? 8'hD0 : (c == 3) ? 8'hB0 : 8'hEE;
      wr(0, {8'h00, code});
      sr_is("R11 unknown code", 8'hB0);
      wr(0, 16'h00FF);
      arr_is("R12 read array with errors", 6'd9);
      wr(0, 16'h0070);
      sr_is("R12 still set", 8'hB0);
      wr(0, 16'h0050);
      sr_is("R12 cleared", 8'h80);
    end
    wr(0, 16'h0020);
    wr(6'd40, 16'h00FF);
    sr_is("R11 bad erase confirm", 8'hB0);
    wr(0, 16'h0050);
    wr(0, 16'h00FF);
    arr_is("R11 no erase", 6'd40);

    // R6 supply low and protect
    vpp_ok = 1'b0;
    wr(0, 16'h0040); wr(6'd20, 16'h0000);
    sr_is("R6 program vpp low", 8'h98);
    wr(0, 16'h0020); wr(6'd20, 16'h00D0);
    sr_is("R6 erase vpp low", 8'hB8);
    wr(0, 16'h0050);
    sr_is("R12 clear after R6", 8'h80);
    vpp_ok = 1'b1; protect = 1'b1;
    wr(0, 16'h0010); wr(6'd3, 16'h0000);
    sr_is("R6 program locked", 8'h92);
    wr(0, 16'h0050);
    wr(0, 16'h0020); wr(6'd2, 16'h00D0);
    sr_is("R6 erase locked", 8'hA2);
    wr(0, 16'h0050);
    protect = 1'b0;
    wr(0, 16'h00FF);
    arr_is("R6 word unchanged vpp", 6'd20);
    arr_is("R6 word unchanged lock", 6'd3);

    // R7 plain erase of block 3
    wr(0, 16'h0020);
    wr(6'd48, 16'h00D0);
    step(ERASE_CYC - 2);
    sr_is("R7 erase busy", 8'h00);
    step(1);
    sr_is("R7 erase done", 8'h80);
    for (int a = 48; a < 64; a++) model[a] = 16'hFFFF;
    wr(0, 16'h00FF);
    for (int a = 48; a < 64; a++) arr_is("R7 block erased", 6'(a));

    // R8 R9 R10 suspend, program elsewhere, deferred resume
    wr(0, 16'h0020);
    wr(6'd32, 16'h00D0);
    wr(0, 16'h00B0);
    sr_is("R8 suspend pending", 8'h00);
    step(SUSP_LAT - 2);
    sr_is("R8 suspend pending", 8'h00);
    step(1);
    sr_is("R8 suspended", 8'hC0);
    wr(0, 16'h0050);
    sr_is("R9 clear ignored in suspend", 8'hC0);
    wr(0, 16'h00FF);
    arr_is("R9 read array in suspend", 6'd32);
    wr(0, 16'h0040); wr(6'd33, 16'h0000);
    sr_is("R9 program suspended block rejected", 8'hD0);
    wr(0, 16'h00FF);
    arr_is("R9 suspended block unchanged", 6'd33);
    wr(0, 16'h0040); wr(6'd17, 16'h0F0F);
    sr_is("R9 program in suspend", 8'h50);
    wr(0, 16'h00D0);
    sr_is("R10 resume deferred", 8'h50);
    step(PROG_CYC - 3);
    sr_is("R10 resumed after program", 8'h10);
    step(ERASE_CYC - 3);
    sr_is("R10 erase continues", 8'h10);
    step(1);
    sr_is("R10 erase complete", 8'h90);
    model[17] = model[17] & 16'h0F0F;
    for (int a = 32; a < 48; a++) model[a] = 16'hFFFF;
    wr(0, 16'h0050);
    sr_is("R12 clear after suspend", 8'h80);
    wr(0, 16'h00FF);
    arr_is("R9 program in other block", 6'd17);
    for (int a = 32; a < 48; a++) arr_is("R10 block erased", 6'(a));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule